// File: doc/BRIEF.md
# DMA Channel Event Status and Interrupt Bank

This block keeps the event flags of every channel of a multi-channel DMA engine and drives one interrupt line per channel. The transfer engine pulses per-channel event bits (timeout, dropped synchronization request, block done and three further progress events). Each pulse is latched into that channel's status register. A per-channel enable mask chooses which latched events raise the channel's interrupt line. Software reads a channel's status through a small register port, and the read clears what it returns.

A single global control input selects a compatibility arrangement with only nine channels. In that arrangement the three highest channels (6, 7 and 8) fold into channels 0, 1 and 2. Their flags appear in the upper bits of the lower channel's status word, and their interrupts leave on the lower channel's line. One status read on the lower channel then serves both channels. Event generation and transfer control lie outside this block.

Top module: `dma_chan_stat`

## Requirements
- R1: After reset every status register reads 0, every interrupt line is low, and every enable register reads 0x0023 (bit 0 timeout, bit 1 sync drop, bit 5 block done).
- R2: A pulse on event bit k of channel c sets status bit k of that channel. The bit stays set until a status read of that channel, and later pulses on other bits add to it.
- R3: The address is {channel, select}, where select 0 is status and select 1 is enable. A status read puts {zeros, flags[5:0]} on rdata in the cycle after rd_en and clears the channel's flags. rdata holds its value while no read is made.
- R4: An event that arrives in the same cycle as a clearing read is not lost. It is absent from that read's data and present in the next read.
- R5: Outside the compatibility arrangement, irq[c] is high exactly when some latched flag of channel c has its enable bit set. Flags that are not enabled still latch.
- R6: A write with select 1 loads bits 5:0 into the channel's enable register, which reads back zero-extended. Writing 0 silences the channel's interrupt but leaves its flags latched.
- R7: Writes with select 0 (status) have no effect.
- R8: In compatibility mode, a status read of channel c in 0..2 returns the flags of channel c+6 in bits 12:7 and its own flags in bits 5:0, and it clears both channels.
- R9: In compatibility mode, irq[c] for c in 0..2 also rises for enabled flags of channel c+6, masked by channel c+6's own enable register. Lines 6..15 stay low, and channels 3..5 behave as in normal mode.
- R10: In compatibility mode, channels 9..15 ignore events and hold no flags. A status read of any channel 6..15 returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| compat_i | input | 1 | Global compatibility arrangement select |
| evt_i | input | NUM_CH*EVT_W | Event pulses, channel c at bits [c*EVT_W +: EVT_W] |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | $clog2(NUM_CH)+1 | {channel, select} |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | NUM_CH | Per-channel interrupt lines |

## Verification
Two functions of this block can fall in the same cycle: the engine latching an event and software clearing the status by reading it. The bench first leaves one flag pending on a channel. It then drives a new event bit and a status read of that channel on the same clock edge. The check expects the read to return only the old flag, the interrupt line to stay up because of the new flag, and a second read to return only the new bit. A similar collision in compatibility mode comes from a read that clears a channel and its folded partner together, followed by checks that both are empty.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

   // register select carried in address bit 0
   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_ENABLE = 1'b1
   } reg_sel_e;

   // event bit positions inside the low status field
   localparam int unsigned EV_TIMEOUT = 0;
   localparam int unsigned EV_DROP    = 1;
   localparam int unsigned EV_BLOCK   = 5;

   // enable mask applied at reset
   localparam int unsigned EN_DEFAULT = (1 << EV_TIMEOUT) | (1 << EV_DROP) | (1 << EV_BLOCK);

endpackage

// File: rtl/dsr_chan.sv
module dsr_chan #(
   parameter int unsigned EVT_W  = 6,
   parameter int unsigned EN_RST = 'h23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             live,
   input  logic [EVT_W-1:0] evt,
   input  logic             clr,
   input  logic             en_we,
   input  logic [EVT_W-1:0] en_wd,
   output logic [EVT_W-1:0] flags_o,
   output logic [EVT_W-1:0] en_o
);

   localparam logic [EVT_W-1:0] EN_INIT = EVT_W'(EN_RST);

   logic [EVT_W-1:0] flags_q;
   logic [EVT_W-1:0] en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         en_q    <= EN_INIT;
      end else begin
         if (!live)
            flags_q <= '0;
         else if (clr)
            flags_q <= evt;
         else
            flags_q <= flags_q | evt;
         if (en_we)
            en_q <= en_wd;
      end
   end

   assign flags_o = flags_q;
   assign en_o    = en_q;

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !clr) |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R2
   AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (live && clr) |=> ((flags_o & ~$past(evt)) == '0)); // R3
   AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      live |=> ((flags_o & $past(evt)) == $past(evt))); // R4
   AST_DEAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !live |=> (flags_o == '0)); // R10

endmodule

// File: rtl/dsr_route.sv
module dsr_route #(
   parameter int unsigned NUM_CH    = 16,
   parameter int unsigned EVT_W     = 6,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned FOLD_BASE = 6,
   parameter int unsigned FOLD_CNT  = 3,
   parameter int unsigned FOLD_LSB  = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     compat,
   input  logic [NUM_CH*EVT_W-1:0]  flags_all,
   input  logic [NUM_CH*EVT_W-1:0]  en_all,
   input  logic [NUM_CH-1:0]        rd_hit,
   output logic [NUM_CH-1:0]        live,
   output logic [NUM_CH-1:0]        clr,
   output logic [NUM_CH*DATA_W-1:0] view_all,
   output logic [NUM_CH-1:0]        irq
);

   localparam int unsigned        COMPAT_CH = FOLD_BASE + FOLD_CNT;
   localparam logic [NUM_CH-1:0]  HI_MASK   = {NUM_CH{1'b1}} << FOLD_BASE;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [EVT_W-1:0]  own_f;
      logic [EVT_W-1:0]  own_e;
      logic [DATA_W-1:0] own_view;
      logic              own_pend;

      assign own_f    = flags_all[c*EVT_W +: EVT_W];
      assign own_e    = en_all[c*EVT_W +: EVT_W];
      assign own_view = DATA_W'(own_f);
      assign own_pend = |(own_f & own_e);

      if (c < FOLD_CNT) begin : g_host
         logic [EVT_W-1:0]  part_f;
         logic [EVT_W-1:0]  part_e;
         logic [DATA_W-1:0] part_view;
         logic              part_pend;

         assign part_f    = flags_all[(c+FOLD_BASE)*EVT_W +: EVT_W];
         assign part_e    = en_all[(c+FOLD_BASE)*EVT_W +: EVT_W];
         assign part_view = DATA_W'(part_f) << FOLD_LSB;
         assign part_pend = |(part_f & part_e);

         assign live[c] = 1'b1;
         assign clr[c]  = rd_hit[c];
         assign irq[c]  = own_pend | (compat & part_pend);
         assign view_all[c*DATA_W +: DATA_W] = compat ? (own_view | part_view) : own_view;

         AST_FOLD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
            (compat && part_pend) |-> irq[c]); // R9
      end else if (c >= FOLD_BASE && c < COMPAT_CH) begin : g_guest
         assign live[c] = 1'b1;
         assign clr[c]  = compat ? rd_hit[c-FOLD_BASE] : rd_hit[c];
         assign irq[c]  = ~compat & own_pend;
         assign view_all[c*DATA_W +: DATA_W] = compat ? '0 : own_view;
      end else if (c >= COMPAT_CH) begin : g_extra
         assign live[c] = ~compat;
         assign clr[c]  = ~compat & rd_hit[c];
         assign irq[c]  = ~compat & own_pend;
         assign view_all[c*DATA_W +: DATA_W] = compat ? '0 : own_view;
      end else begin : g_plain
         assign live[c] = 1'b1;
         assign clr[c]  = rd_hit[c];
         assign irq[c]  = own_pend;
         assign view_all[c*DATA_W +: DATA_W] = own_view;
      end
   end

   AST_SHARED_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      compat |-> ((irq & HI_MASK) == '0)); // R9

endmodule

// File: rtl/dma_chan_stat.sv
module dma_chan_stat #(
   parameter int unsigned NUM_CH    = 16,
   parameter int unsigned EVT_W     = 6,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned FOLD_BASE = 6,
   parameter int unsigned FOLD_CNT  = 3,
   parameter int unsigned FOLD_LSB  = 7,
   parameter int unsigned EN_RST    = dsr_pkg::EN_DEFAULT
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      compat_i,
   input  logic [NUM_CH*EVT_W-1:0]   evt_i,
   input  logic                      rd_en_i,
   input  logic                      wr_en_i,
   input  logic [$clog2(NUM_CH):0]   addr_i,
   input  logic [DATA_W-1:0]         wdata_i,
   output logic [DATA_W-1:0]         rdata_o,
   output logic [NUM_CH-1:0]         irq_o
);
   import dsr_pkg::*;

   localparam int unsigned CH_W = $clog2(NUM_CH);

   // elaboration-time parameter checks
   if (NUM_CH < 2) begin : g_bad_num
      $error("NUM_CH must be at least 2");
   end
   if (FOLD_BASE + FOLD_CNT > NUM_CH) begin : g_bad_fold
      $error("folded channels exceed NUM_CH");
   end
   if (FOLD_CNT > FOLD_BASE) begin : g_bad_overlap
      $error("host and folded channel ranges overlap");
   end
   if (FOLD_LSB < EVT_W || FOLD_LSB + EVT_W > DATA_W) begin : g_bad_lsb
      $error("folded field does not fit the status word");
   end

   reg_sel_e                  sel;
   logic [CH_W-1:0]           idx;
   logic [NUM_CH-1:0]         rd_hit;
   logic [NUM_CH-1:0]         en_we;
   logic [NUM_CH-1:0]         live;
   logic [NUM_CH-1:0]         clr;
   logic [NUM_CH*EVT_W-1:0]   flags_all;
   logic [NUM_CH*EVT_W-1:0]   en_all;
   logic [NUM_CH*DATA_W-1:0]  view_all;
   logic [DATA_W-1:0]         rd_next;
   logic [DATA_W-1:0]         rdata_q;
   logic                      unused_wdata_hi;

   assign sel             = reg_sel_e'(addr_i[0]);
   assign idx             = addr_i[CH_W:1];
   assign unused_wdata_hi = ^wdata_i[DATA_W-1:EVT_W];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign rd_hit[c] = rd_en_i && (sel == SEL_STATUS) && (idx == CH_W'(c));
      assign en_we[c]  = wr_en_i && (sel == SEL_ENABLE) && (idx == CH_W'(c));

      dsr_chan #(
         .EVT_W  (EVT_W),
         .EN_RST (EN_RST)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .live    (live[c]),
         .evt     (evt_i[c*EVT_W +: EVT_W]),
         .clr     (clr[c]),
         .en_we   (en_we[c]),
         .en_wd   (wdata_i[EVT_W-1:0]),
         .flags_o (flags_all[c*EVT_W +: EVT_W]),
         .en_o    (en_all[c*EVT_W +: EVT_W])
      );
   end

   dsr_route #(
      .NUM_CH    (NUM_CH),
      .EVT_W     (EVT_W),
      .DATA_W    (DATA_W),
      .FOLD_BASE (FOLD_BASE),
      .FOLD_CNT  (FOLD_CNT),
      .FOLD_LSB  (FOLD_LSB)
   ) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .compat    (compat_i),
      .flags_all (flags_all),
      .en_all    (en_all),
      .rd_hit    (rd_hit),
      .live      (live),
      .clr       (clr),
      .view_all  (view_all),
      .irq       (irq_o)
   );

   always_comb begin
      rd_next = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (idx == CH_W'(c))
            rd_next = (sel == SEL_ENABLE) ? DATA_W'(en_all[c*EVT_W +: EVT_W])
                                          : view_all[c*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_en_i)
         rdata_q <= rd_next;
   end

   assign rdata_o = rdata_q;

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rdata_o)); // R3
   AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !compat_i && (sel == SEL_STATUS) && (evt_i == '0))
         |=> (irq_o[$past(idx)] == 1'b0)); // R3

endmodule

// File: tb/dma_chan_stat_test.sv
module dma_chan_stat_test;

   localparam int NCH = 16;
   localparam int EW  = 6;
   localparam int DW  = 16;

   localparam logic [1:0] OP_EV = 2'd0;
   localparam logic [1:0] OP_WR = 2'd1;
   localparam logic [1:0] OP_RD = 2'd2;
   localparam logic [1:0] OP_IQ = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic        cm;
      logic [3:0]  ch;
      logic        sel;
      logic [15:0] dat;
      logic [15:0] exp;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 39;
   localparam vec_t VT [NV] = '{
      '{OP_RD, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h0000, 4'd1},  // R1 status empty
      '{OP_RD, 1'b0, 4'd0,  1'b1, 16'h0000, 16'h0023, 4'd1},  // R1 default enable
      '{OP_IQ, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h0000, 4'd1},  // R1 lines low
      '{OP_EV, 1'b0, 4'd3,  1'b0, 16'h0001, 16'h0000, 4'd2},  // R2 timeout
      '{OP_IQ, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h0008, 4'd5},  // R5
      '{OP_EV, 1'b0, 4'd3,  1'b0, 16'h0020, 16'h0000, 4'd2},  // R2 block done
      '{OP_RD, 1'b0, 4'd3,  1'b0, 16'h0000, 16'h0021, 4'd2},  // R2 accumulated
      '{OP_RD, 1'b0, 4'd3,  1'b0, 16'h0000, 16'h0000, 4'd3},  // R3 cleared
      '{OP_IQ, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h0000, 4'd3},  // R3
      '{OP_EV, 1'b0, 4'd15, 1'b0, 16'h0004, 16'h0000, 4'd5},  // R5 masked bit
      '{OP_IQ, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h0000, 4'd5},  // R5
      '{OP_WR, 1'b0, 4'd15, 1'b1, 16'hFF04, 16'h0000, 4'd6},  // R6
      '{OP_IQ, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h8000, 4'd6},  // R6
      '{OP_RD, 1'b0, 4'd15, 1'b1, 16'h0000, 16'h0004, 4'd6},  // R6 readback
      '{OP_WR, 1'b0, 4'd15, 1'b1, 16'h0000, 16'h0000, 4'd6},  // R6 zero
      '{OP_IQ, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h0000, 4'd6},  // R6
      '{OP_RD, 1'b0, 4'd15, 1'b0, 16'h0000, 16'h0004, 4'd6},  // R6 still latched
      '{OP_EV, 1'b0, 4'd5,  1'b0, 16'h0002, 16'h0000, 4'd7},  // R7
      '{OP_WR, 1'b0, 4'd5,  1'b0, 16'h003F, 16'h0000, 4'd7},  // R7 status write
      '{OP_RD, 1'b0, 4'd5,  1'b0, 16'h0000, 16'h0002, 4'd7},  // R7
      '{OP_EV, 1'b1, 4'd6,  1'b0, 16'h0001, 16'h0000, 4'd9},  // R9
      '{OP_IQ, 1'b1, 4'd0,  1'b0, 16'h0000, 16'h0001, 4'd9},  // R9 shared line
      '{OP_EV, 1'b1, 4'd0,  1'b0, 16'h0020, 16'h0000, 4'd8},  // R8
      '{OP_RD, 1'b1, 4'd6,  1'b0, 16'h0000, 16'h0000, 4'd10}, // R10 guest read
      '{OP_RD, 1'b1, 4'd0,  1'b0, 16'h0000, 16'h00A0, 4'd8},  // R8 folded word
      '{OP_RD, 1'b1, 4'd0,  1'b0, 16'h0000, 16'h0000, 4'd8},  // R8 both cleared
      '{OP_IQ, 1'b1, 4'd0,  1'b0, 16'h0000, 16'h0000, 4'd8},  // R8
      '{OP_EV, 1'b1, 4'd12, 1'b0, 16'h0001, 16'h0000, 4'd10}, // R10 dead channel
      '{OP_IQ, 1'b1, 4'd0,  1'b0, 16'h0000, 16'h0000, 4'd10}, // R10
      '{OP_RD, 1'b1, 4'd12, 1'b0, 16'h0000, 16'h0000, 4'd10}, // R10
      '{OP_RD, 1'b0, 4'd12, 1'b0, 16'h0000, 16'h0000, 4'd10}, // R10 nothing kept
      '{OP_EV, 1'b1, 4'd7,  1'b0, 16'h0002, 16'h0000, 4'd9},  // R9
      '{OP_WR, 1'b1, 4'd7,  1'b1, 16'h0000, 16'h0000, 4'd9},  // R9 guest mask
      '{OP_IQ, 1'b1, 4'd0,  1'b0, 16'h0000, 16'h0000, 4'd9},  // R9
      '{OP_RD, 1'b1, 4'd1,  1'b0, 16'h0000, 16'h0100, 4'd8},  // R8
      '{OP_EV, 1'b1, 4'd4,  1'b0, 16'h0001, 16'h0000, 4'd9},  // R9 plain channel
      '{OP_IQ, 1'b1, 4'd0,  1'b0, 16'h0000, 16'h0010, 4'd9},  // R9
      '{OP_RD, 1'b1, 4'd4,  1'b0, 16'h0000, 16'h0001, 4'd9},  // R9
      '{OP_IQ, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h0000, 4'd5}   // R5
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            compat_i = 1'b0;
   logic [NCH*EW-1:0] evt_i = '0;
   logic            rd_en_i = 1'b0;
   logic            wr_en_i = 1'b0;
   logic [4:0]      addr_i = '0;
   logic [DW-1:0]   wdata_i = '0;
   logic [DW-1:0]   rdata_o;
   logic [NCH-1:0]  irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dma_chan_stat uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .compat_i (compat_i),
      .evt_i    (evt_i),
      .rd_en_i  (rd_en_i),
      .wr_en_i  (wr_en_i),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .rdata_o  (rdata_o),
      .irq_o    (irq_o)
   );

   task automatic check(input string what, input int rq, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s actual=%04h expected=%04h", rq, what, act, exp);
      end
   endtask

   task automatic do_read(input logic [3:0] ch, input logic sel);
      addr_i  = {ch, sel};
      rd_en_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_en_i = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      @(negedge clk);
      compat_i = v.cm;
      case (v.op)
         OP_EV: begin
            evt_i = '0;
            evt_i[v.ch*EW +: EW] = v.dat[EW-1:0];
            @(posedge clk);
            @(negedge clk);
            evt_i = '0;
         end
         OP_WR: begin
            addr_i  = {v.ch, v.sel};
            wdata_i = v.dat;
            wr_en_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            wr_en_i = 1'b0;
         end
         OP_RD: begin
            do_read(v.ch, v.sel);
            check("table read", int'(v.rq), rdata_o, v.exp);
         end
         default: check("table irq", int'(v.rq), irq_o, v.exp);
      endcase
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++)
         run_vec(VT[i]);

      // R4: event and clearing read on the same edge
      @(negedge clk);
      compat_i = 1'b0;
      evt_i = '0;
      evt_i[2*EW +: EW] = 6'h02;
      @(posedge clk);
      @(negedge clk);
      evt_i = '0;
      evt_i[2*EW +: EW] = 6'h01;
      addr_i  = {4'd2, 1'b0};
      rd_en_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      evt_i   = '0;
      rd_en_i = 1'b0;
      check("collision read old flag", 4, rdata_o, 16'h0002);
      check("collision irq new flag", 4, irq_o, 16'h0004);
      do_read(4'd2, 1'b0);
      check("collision new flag kept", 4, rdata_o, 16'h0001);
      do_read(4'd2, 1'b0);
      check("collision then empty", 4, rdata_o, 16'h0000);

      // R3: rdata holds while idle
      @(negedge clk);
      evt_i[9*EW +: EW] = 6'h20;
      @(posedge clk);
      @(negedge clk);
      evt_i = '0;
      @(posedge clk);
      @(negedge clk);
      check("rdata held without read", 3, rdata_o, 16'h0000);
      check("block flag raises line", 5, irq_o, 16'h0200);

      // R1: reset mid-run restores defaults
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("reset lines low", 1, irq_o, 16'h0000);
      check("reset rdata", 1, rdata_o, 16'h0000);
      rst_n = 1'b1;
      do_read(4'd15, 1'b1);
      check("reset enable ch15", 1, rdata_o, 16'h0023);
      do_read(4'd7, 1'b1);
      check("reset enable ch7", 1, rdata_o, 16'h0023);
      do_read(4'd9, 1'b0);
      check("reset status ch9", 1, rdata_o, 16'h0000);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule